// File: doc/BRIEF.md
# Serial Command Slave with Configuration Store and Sample Packetiser

This block is the host-facing serial port of a multi-channel acquisition chip. A host frames a transaction by pulling a chip-select low and clocking bits in on a serial data line. The block samples the serial clock, the chip-select and the data line with a fast system clock. The first two bits of each frame are a command. The command can load a 20-bit settings word, read that word back, or read the latest pair of converter samples. A sample read returns a small packet: a channel-one marker, an error-correction-active flag and the two samples. When error correction is enabled, 16 parity bits from an external encoder follow.

The converter side presents a 20-bit sample word, a channel-one flag and the parity bits, together with an end-of-conversion strobe. On that strobe all three are captured into a holding register. The strobe is also passed back to the host as an interrupt request. For daisy chaining, the incoming serial data is passed on to the next chip delayed by one full 22-bit frame. After the local read packet ends, the serial output carries the next chip's return data unchanged. The settings word drives three fields into the chip: the encoder enable, the multiplexer enable and a 4-bit post-gain code. All zero is the usable power-on setting.

The controller has seven named states:
- `ST_IDLE`: chip-select is high.
- `ST_CMD`: the two command bits are being collected.
- `ST_NOP`: the frame carries command 00.
- `ST_WRITE`: settings bits are being collected.
- `ST_WR_FULL`: all 20 settings bits are held.
- `ST_RD_ADC`: the sample packet is being shifted out.
- `ST_RD_CFG`: the settings word is being shifted out.

The transitions are:
- `ST_IDLE` moves to `ST_CMD` when chip-select goes low.
- On the second rising clock edge, `ST_CMD` moves to one of `ST_NOP`, `ST_WRITE`, `ST_RD_ADC` or `ST_RD_CFG`, as the command decodes.
- On the 22nd rising clock edge, `ST_WRITE` moves to `ST_WR_FULL`.
- Every state returns to `ST_IDLE` when chip-select goes high. If the state was `ST_WR_FULL` at that moment, the settings register is committed.

Top module: `spi_acq_slave`

## Requirements
- R1: After reset, the encoder enable, multiplexer enable and gain outputs are 0. The serial output, the chain output and the interrupt are also 0.
- R2: A frame is the bits clocked while `cs_n` is low. `mosi` is taken on each rising `sclk` edge, most significant bit first. `miso` changes only after falling `sclk` edges, so it can be read just before each rising edge.
- R3: Command 01 stores frame bits 2..21 as the settings word, first received bit in settings bit 19. The store happens when `cs_n` rises, and only if at least 22 rising edges occurred in the frame. Bits past the 22nd do not alter the stored word.
- R4: Settings bit 19 drives `cfg_ecc_en`, bit 18 drives `cfg_mux_en`, and bits 17..14 drive `cfg_gain`. The other bits are stored and read back.
- R5: A frame with command 01 and fewer than 22 rising edges leaves the settings word unchanged.
- R6: Command 11 returns the settings word, bit 19 first. Settings bit 19-k is valid before rising edge k+2, for k = 0..19.
- R7: Command 10 with bit 19 clear returns 22 bits, valid before rising edges 2..23. In order they are: the held channel-one flag, a 0, then the held 20-bit sample word, bit 19 first.
- R8: Command 10 with bit 19 set returns 38 bits. In order they are: the channel-one flag, a 1, the sample word, then the held 16-bit parity, bit 15 first.
- R9: The sample word, channel-one flag and parity are captured only on a cycle with `eoc` high. Input changes without `eoc` are not seen. A strobe during a read does not alter the packet being sent, because the packet is frozen when the command is decoded.
- R10: `irq` is high in the system-clock cycle after each cycle in which `eoc` is high.
- R11: `chain_mosi_out` is 0 until 22 rising edges have occurred in the frame. Before rising edge j (j ≥ 22) it shows frame bit j-22.
- R12: In a read frame, once the local packet is finished, `miso` follows `chain_miso_in`.
- R13: During a command 00 frame, `miso` is 0 and the settings word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| glob_rst | input | 1 | Asynchronous global reset, active high |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Frame select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| chain_mosi_out | output | 1 | Host data delayed one frame, toward the next chip |
| chain_miso_in | input | 1 | Return data from the next chip |
| eoc | input | 1 | End-of-conversion strobe |
| adc_data | input | 20 | Two 10-bit samples |
| ch1_flag | input | 1 | Channel-one marker from the encoder |
| ecc_parity | input | 16 | Parity bits from the encoder |
| irq | output | 1 | Interrupt request to host |
| cfg_ecc_en | output | 1 | Encoder enable |
| cfg_mux_en | output | 1 | Multiplexer enable |
| cfg_gain | output | 4 | Post-amplifier gain code |

## Verification
The bench builds the block with its defaults: two 10-bit samples, 16 parity bits, a 20-bit settings word and two synchronizer stages. These values give a 22-bit command frame and packets of 22 or 38 bits. They bring within reach both packet lengths, the exact 22-edge threshold for a write, and the one-frame chain delay. The serial clock runs at eight system clocks per half period, which covers the synchronizer and edge-detect latency. Random settings words and sample captures are mixed with directed cases. These cases are a short write, an idle frame, a strobe in the middle of a read, and frames longer than the local packet.

// File: rtl/spi_acq_pkg.sv
package spi_acq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_NOP,
        ST_WRITE,
        ST_WR_FULL,
        ST_RD_ADC,
        ST_RD_CFG
    } acq_state_t;

    localparam logic [1:0] CMD_NOP    = 2'b00;
    localparam logic [1:0] CMD_WR     = 2'b01;
    localparam logic [1:0] CMD_RD_ADC = 2'b10;
    localparam logic [1:0] CMD_RD_CFG = 2'b11;

    localparam int CFG_ECC_BIT = 19;
    localparam int CFG_MUX_BIT = 18;
    localparam int CFG_GAIN_HI = 17;
    localparam int CFG_GAIN_LO = 14;

endpackage

// File: rtl/spi_acq_sync.sv
module spi_acq_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or posedge rst) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or posedge rst) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_acq_hold.sv
module spi_acq_hold #(
    parameter int DATA_W = 20,
    parameter int PAR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eoc,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ch1_in,
    input  logic [PAR_W-1:0]  par_in,
    output logic [DATA_W-1:0] data_q,
    output logic              ch1_q,
    output logic [PAR_W-1:0]  par_q,
    output logic              irq_q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            data_q <= '0;
            ch1_q  <= 1'b0;
            par_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= eoc;
            if (eoc) begin
                data_q <= data_in;
                ch1_q  <= ch1_in;
                par_q  <= par_in;
            end
        end
    end

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
        eoc |=> irq_q);

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !eoc |=> $stable(data_q) && $stable(par_q) && $stable(ch1_q));
endmodule

// File: rtl/spi_acq_delay.sv
module spi_acq_delay #(
    parameter int DEPTH = 22
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] line_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)      line_q <= '0;
        else if (clr) line_q <= '0;
        else if (en)  line_q <= {line_q[DEPTH-2:0], din};
    end

    assign dout = line_q[DEPTH-1];
endmodule

// File: rtl/spi_acq_slave.sv
module spi_acq_slave
    import spi_acq_pkg::*;
#(
    parameter int SAMPLE_W    = 10,
    parameter int N_ADC       = 2,
    parameter int PAR_W       = 16,
    parameter int CFG_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        glob_rst,
    input  logic                        sclk,
    input  logic                        cs_n,
    input  logic                        mosi,
    output logic                        miso,
    output logic                        chain_mosi_out,
    input  logic                        chain_miso_in,
    input  logic                        eoc,
    input  logic [SAMPLE_W*N_ADC-1:0]   adc_data,
    input  logic                        ch1_flag,
    input  logic [PAR_W-1:0]            ecc_parity,
    output logic                        irq,
    output logic                        cfg_ecc_en,
    output logic                        cfg_mux_en,
    output logic [3:0]                  cfg_gain
);
    localparam int CMD_W     = 2;
    localparam int DATA_W    = SAMPLE_W * N_ADC;
    localparam int FRAME_LEN = CMD_W + CFG_W;
    localparam int PKT_BASE  = 2 + DATA_W;
    localparam int PKT_MAX   = PKT_BASE + PAR_W;
    localparam int CNT_W     = $clog2(PKT_MAX + CMD_W + 1) + 1;
    localparam int LEFT_W    = $clog2(PKT_MAX + 1);

    logic sclk_s, cs_s, mosi_s;
    logic sclk_d, cs_d;
    logic sclk_rise, sclk_fall, cs_end;

    acq_state_t st_q, st_nx;

    logic [CNT_W-1:0]  bit_cnt;
    logic [CMD_W-2:0]  cmd_sh;
    logic [CMD_W-1:0]  cmd_nx;
    logic [CFG_W-1:0]  wr_sh;
    logic [CFG_W-1:0]  cfg_q;
    logic [PKT_MAX-1:0] pkt_sh;
    logic [PKT_MAX-1:0] adc_pkt;
    logic [LEFT_W-1:0] left_q;
    logic              tx_bit, pass_q;
    logic              cmd_done, load_adc, load_cfg, commit, rd_state;

    logic [DATA_W-1:0] hold_data;
    logic              hold_ch1;
    logic [PAR_W-1:0]  hold_par;

    spi_acq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (glob_rst),
        .d   ({sclk, cs_n, mosi}),
        .q   ({sclk_s, cs_s, mosi_s})
    );

    spi_acq_hold #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_hold (
        .clk     (clk),
        .rst     (glob_rst),
        .eoc     (eoc),
        .data_in (adc_data),
        .ch1_in  (ch1_flag),
        .par_in  (ecc_parity),
        .data_q  (hold_data),
        .ch1_q   (hold_ch1),
        .par_q   (hold_par),
        .irq_q   (irq)
    );

    spi_acq_delay #(.DEPTH(FRAME_LEN)) u_chain (
        .clk  (clk),
        .rst  (glob_rst),
        .clr  (cs_s),
        .en   (sclk_rise),
        .din  (mosi_s),
        .dout (chain_mosi_out)
    );

    always_ff @(posedge clk or posedge glob_rst) begin
        if (glob_rst) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_end    = cs_s & ~cs_d;

    assign cmd_nx   = {cmd_sh, mosi_s};
    assign cmd_done = (st_q == ST_CMD) && sclk_rise && (bit_cnt == CNT_W'(CMD_W - 1));
    assign load_adc = cmd_done && (cmd_nx == CMD_RD_ADC);
    assign load_cfg = cmd_done && (cmd_nx == CMD_RD_CFG);
    assign commit   = cs_end && (st_q == ST_WR_FULL);
    assign rd_state = (st_q == ST_RD_ADC) || (st_q == ST_RD_CFG);

    assign adc_pkt = {hold_ch1, cfg_q[CFG_ECC_BIT], hold_data,
                      cfg_q[CFG_ECC_BIT] ? hold_par : {PAR_W{1'b0}}};

    // State register
    always_ff @(posedge clk or posedge glob_rst) begin
        if (glob_rst) st_q <= ST_IDLE;
        else          st_q <= st_nx;
    end

    // Next-state logic
    always_comb begin
        st_nx = st_q;
        if (cs_s) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:    st_nx = ST_CMD;
                ST_CMD: begin
                    if (cmd_done) begin
                        unique case (cmd_nx)
                            CMD_NOP:    st_nx = ST_NOP;
                            CMD_WR:     st_nx = ST_WRITE;
                            CMD_RD_ADC: st_nx = ST_RD_ADC;
                            CMD_RD_CFG: st_nx = ST_RD_CFG;
                        endcase
                    end
                end
                ST_WRITE: begin
                    if (sclk_rise && bit_cnt == CNT_W'(FRAME_LEN - 1))
                        st_nx = ST_WR_FULL;
                end
                ST_NOP:     st_nx = ST_NOP;
                ST_WR_FULL: st_nx = ST_WR_FULL;
                ST_RD_ADC:  st_nx = ST_RD_ADC;
                ST_RD_CFG:  st_nx = ST_RD_CFG;
            endcase
        end
    end

    // Frame datapath
    always_ff @(posedge clk or posedge glob_rst) begin
        if (glob_rst) begin
            bit_cnt <= '0;
            cmd_sh  <= '0;
            wr_sh   <= '0;
            cfg_q   <= '0;
            pkt_sh  <= '0;
            left_q  <= '0;
            tx_bit  <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            if (cs_s)
                bit_cnt <= '0;
            else if (sclk_rise && bit_cnt != {CNT_W{1'b1}})
                bit_cnt <= bit_cnt + 1'b1;

            if (sclk_rise && st_q == ST_CMD)
                cmd_sh <= cmd_nx[CMD_W-2:0];
            if (sclk_rise && st_q == ST_WRITE)
                wr_sh <= {wr_sh[CFG_W-2:0], mosi_s};
            if (commit)
                cfg_q <= wr_sh;

            if (cs_s) begin
                tx_bit <= 1'b0;
                pass_q <= 1'b0;
                left_q <= '0;
            end else if (load_adc) begin
                pkt_sh <= adc_pkt;
                left_q <= cfg_q[CFG_ECC_BIT] ? LEFT_W'(PKT_MAX) : LEFT_W'(PKT_BASE);
            end else if (load_cfg) begin
                pkt_sh <= {cfg_q, {(PKT_MAX-CFG_W){1'b0}}};
                left_q <= LEFT_W'(CFG_W);
            end else if (sclk_fall && rd_state) begin
                if (left_q != '0) begin
                    tx_bit <= pkt_sh[PKT_MAX-1];
                    pkt_sh <= pkt_sh << 1;
                    left_q <= left_q - 1'b1;
                end else begin
                    pass_q <= 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        miso = 1'b0;
        if (rd_state)
            miso = pass_q ? chain_miso_in : tx_bit;
        cfg_ecc_en = cfg_q[CFG_ECC_BIT];
        cfg_mux_en = cfg_q[CFG_MUX_BIT];
        cfg_gain   = cfg_q[CFG_GAIN_HI:CFG_GAIN_LO];
    end

    assert_short_write_kept_R5: assert property (@(posedge clk) disable iff (glob_rst)
        (cs_end && st_q != ST_WR_FULL) |=> $stable(cfg_q));

    assert_commit_full_frame_R3: assert property (@(posedge clk) disable iff (glob_rst)
        commit |-> bit_cnt >= CNT_W'(FRAME_LEN));

    assert_nop_quiet_R13: assert property (@(posedge clk) disable iff (glob_rst)
        (st_q == ST_NOP || st_q == ST_IDLE) |-> !miso);

    assert_chain_quiet_R11: assert property (@(posedge clk) disable iff (glob_rst)
        (bit_cnt < CNT_W'(FRAME_LEN)) |-> !chain_mosi_out);

    assert_miso_edge_R2: assert property (@(posedge clk) disable iff (glob_rst)
        (!cs_s && !sclk_fall && !pass_q) |=> $stable(tx_bit));
endmodule

// File: tb/sim_spi_acq_slave.sv
module sim_spi_acq_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HP = 8;

    logic clk = 1'b0;
    logic glob_rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, chain_mosi_out, chain_miso_in = 1'b0;
    logic eoc = 1'b0;
    logic [19:0] adc_data = '0;
    logic ch1_flag = 1'b0;
    logic [15:0] ecc_parity = '0;
    logic irq, cfg_ecc_en, cfg_mux_en;
    logic [3:0] cfg_gain;

    int checks = 0;
    int errors = 0;

    logic bits [64];
    logic miso_cap [64];
    logic chain_cap [64];

    logic [19:0] cur_cfg = '0;
    logic [19:0] h_data = '0;
    logic        h_ch1 = 1'b0;
    logic [15:0] h_par = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_acq_slave u0 (
        .clk(clk), .glob_rst(glob_rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .chain_mosi_out(chain_mosi_out), .chain_miso_in(chain_miso_in),
        .eoc(eoc), .adc_data(adc_data), .ch1_flag(ch1_flag), .ecc_parity(ecc_parity),
        .irq(irq), .cfg_ecc_en(cfg_ecc_en), .cfg_mux_en(cfg_mux_en), .cfg_gain(cfg_gain)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [37:0] exp_pkt(input logic ch1, input logic ecc,
                                             input logic [19:0] d, input logic [15:0] p);
        return {ch1, ecc, d, ecc ? p : 16'h0};
    endfunction

    task automatic load_frame(input logic [1:0] cmd, input logic [19:0] data);
        for (int i = 0; i < 64; i++) bits[i] = 1'b0;
        bits[0] = cmd[1];
        bits[1] = cmd[0];
        for (int i = 0; i < 20; i++) bits[2+i] = data[19-i];
    endtask

    // mid_k >= 0 pulses eoc with new_data while sclk is low before rise mid_k
    task automatic run_frame(input int n, input int mid_k, input logic [19:0] new_data);
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            mosi = bits[i];
            if (i == mid_k) begin
                adc_data = new_data;
                eoc = 1'b1;
                @(negedge clk);
                eoc = 1'b0;
                repeat (HP-1) @(negedge clk);
            end else begin
                repeat (HP) @(negedge clk);
            end
            miso_cap[i] = miso;
            chain_cap[i] = chain_mosi_out;
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (2*HP) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [19:0] v, input int n);
        load_frame(2'b01, v);
        run_frame(n, -1, '0);
        if (n >= 22) cur_cfg = v;
    endtask

    task automatic read_cfg_check(input string req);
        logic [19:0] got;
        load_frame(2'b11, $urandom());
        run_frame(22, -1, '0);
        for (int k = 0; k < 20; k++) got[19-k] = miso_cap[k+2];
        check(req, {44'h0, got}, {44'h0, cur_cfg});
    endtask

    task automatic check_fields(input string req);
        check(req, {60'h0, cfg_ecc_en, cfg_mux_en, cfg_gain[3:2]}, {60'h0, cur_cfg[19], cur_cfg[18], cur_cfg[17:16]});
        check(req, {60'h0, cfg_gain}, {60'h0, cur_cfg[17:14]});
    endtask

    task automatic strobe(input logic [19:0] d, input logic c, input logic [15:0] p);
        adc_data = d; ch1_flag = c; ecc_parity = p;
        eoc = 1'b1;
        @(negedge clk);
        eoc = 1'b0;
        check("R10 irq after eoc", {63'h0, irq}, 64'h1);
        @(negedge clk);
        check("R10 irq clears", {63'h0, irq}, 64'h0);
        h_data = d; h_ch1 = c; h_par = p;
    endtask

    task automatic read_adc_check(input string req, input int extra, input int mid_k,
                                  input logic [19:0] new_data);
        int len;
        logic [37:0] exp;
        logic [37:0] got;
        logic bad_pass;
        len = cur_cfg[19] ? 38 : 22;
        exp = exp_pkt(h_ch1, cur_cfg[19], h_data, h_par);
        load_frame(2'b10, $urandom());
        run_frame(2 + len + extra, mid_k, new_data);
        got = '0;
        for (int k = 0; k < len; k++) got[37-k] = miso_cap[k+2];
        check(req, {26'h0, got}, {26'h0, exp});
        bad_pass = 1'b0;
        for (int k = 0; k < extra; k++)
            if (miso_cap[2+len+k] !== chain_miso_in) bad_pass = 1'b1;
        if (extra > 0) check("R12 miso follows chain input", {63'h0, bad_pass}, 64'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [19:0] v;
        logic [19:0] old_data;
        logic bad;
        void'($urandom(32'h5eed1234));
        repeat (5) @(negedge clk);
        glob_rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 cfg outputs", {58'h0, cfg_ecc_en, cfg_mux_en, cfg_gain}, 64'h0);
        check("R1 serial outputs", {61'h0, miso, chain_mosi_out, irq}, 64'h0);

        // R3 R4 R6 R2 write then read back
        write_cfg(20'h5A3C6, 22);
        check_fields("R4 fields after write");
        read_cfg_check("R6 readback");
        write_cfg(20'hC_0000 | 20'h0BCDE, 22);
        check_fields("R4 ecc and mux set");
        read_cfg_check("R3 R2 readback");

        // R5 short write discarded
        write_cfg(20'h3FFFF, 15);
        check_fields("R5 short write fields");
        read_cfg_check("R5 short write readback");
        write_cfg(20'h12345, 21);
        read_cfg_check("R5 21 edges discarded");

        // R13 idle command
        load_frame(2'b00, 20'hFFFFF);
        run_frame(22, -1, '0);
        bad = 1'b0;
        for (int k = 0; k < 22; k++) if (miso_cap[k] !== 1'b0) bad = 1'b1;
        check("R13 nop miso quiet", {63'h0, bad}, 64'h0);
        read_cfg_check("R13 nop leaves cfg");

        // R7 packet without parity
        write_cfg(20'h0_3C00, 22);
        strobe(20'hA5C3F, 1'b1, 16'hBEEF);
        chain_miso_in = 1'b1;
        read_adc_check("R7 packet no parity", 4, -1, '0);

        // R9 input change without strobe ignored
        adc_data = 20'h00001; ch1_flag = 1'b0; ecc_parity = 16'h1111;
        read_adc_check("R9 no strobe no change", 0, -1, '0);

        // R8 packet with parity
        write_cfg(20'h8_0000, 22);
        strobe(20'h6B2D4, 1'b0, 16'hC0DE);
        chain_miso_in = 1'b0;
        read_adc_check("R8 packet with parity", 3, -1, '0);

        // R9 strobe during read does not alter packet
        old_data = h_data;
        read_adc_check("R9 mid-read strobe", 0, 10, 20'h11111);
        h_data = 20'h11111;
        h_ch1 = ch1_flag;
        h_par = ecc_parity;
        read_adc_check("R9 new capture visible next read", 0, -1, '0);
        check("R9 data differed", {63'h0, old_data != h_data}, 64'h1);

        // R11 chain delay and R3 long write
        v = 20'h9E1B7;
        load_frame(2'b01, v);
        for (int i = 22; i < 34; i++) bits[i] = ((i % 3) == 0);
        run_frame(34, -1, '0);
        cur_cfg = v;
        bad = 1'b0;
        for (int j = 0; j < 34; j++)
            if (chain_cap[j] !== ((j >= 22) ? bits[j-22] : 1'b0)) bad = 1'b1;
        check("R11 chain delay", {63'h0, bad}, 64'h0);
        check_fields("R3 long write fields");
        read_cfg_check("R3 long write readback");

        // Random mix
        for (int it = 0; it < 8; it++) begin
            v = $urandom();
            write_cfg(v, 22);
            check_fields("R4 random fields");
            read_cfg_check("R6 random readback");
            strobe($urandom(), $urandom(), $urandom());
            chain_miso_in = $urandom();
            read_adc_check(cur_cfg[19] ? "R8 random" : "R7 random", 2, -1, '0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule